// File: doc/BRIEF.md
# Triggered Sprite Line Shifter

This block holds a single 8-pixel row of a sprite, 4 bits per pixel, and plays it out onto a 320-column logical scanline. A row word, a 9-bit starting column and a mirror flag are captured with one load strobe. The load arms a one-shot trigger. The trigger fires on an enabled cycle in which the incoming logical column equals the stored start. The shifter then steps through the eight pixels, one per enabled cycle.

The enable is expected at half the display rate, taken from the lowest bit of the 640-wide display column. Each logical pixel therefore covers two display pixels. Colour 0 counts as transparent and is never flagged valid. Picking between several sprites, palette lookup, video timing and row fetching are handled by neighbouring logic.

Top module: `sprite_line_shifter`

## Requirements
- R1: After reset the block is idle and unarmed: `color_o` is 0 and `valid_o` is 0, and no trigger can fire until a load has taken place.
- R2: A cycle with `load_i` high captures `row_i`, `xstart_i` and `hflip_i`, and arms the trigger. Load takes priority: no trigger fires and no pixel advances in a load cycle.
- R3: An armed trigger fires on the clock edge of a cycle with `pix_en_i` high and `xpos_i` equal to the stored start. After that edge pixel 0 is on the outputs. Without the enable, a matching column does not fire the trigger.
- R4: The pixel index advances only on edges of cycles with `pix_en_i` high. Between enabled edges the outputs hold their value.
- R5: With the flip flag clear, pixel k (k = 0..7) is bits [4k+3:4k] of the row word: pixel 0 is bits [3:0] and pixel 7 is bits [31:28].
- R6: With the flip flag set, pixel k is bits [31-4k:28-4k], so the emission order is reversed.
- R7: Emission lasts exactly 8 enabled slots and then the block returns to idle. The trigger is one-shot, so a later match without a new load produces nothing.
- R8: A pixel whose value is 0 is transparent: `valid_o` is 0 and `color_o` is 0 for that slot.
- R9: A load during emission discards the current row. Outputs go to 0 after the load edge, and the trigger re-arms with the new start column.
- R10: Whenever no pixel is being emitted, `color_o` is 0 and `valid_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| load_i | input | 1 | Capture row, start and flip; arm the trigger |
| row_i | input | 32 | Eight 4-bit pixels, pixel 0 in the low nibble |
| xstart_i | input | 9 | Logical column at which emission begins |
| hflip_i | input | 1 | Reverse pixel order |
| pix_en_i | input | 1 | Half-rate logical pixel enable |
| xpos_i | input | 9 | Current logical column (0..319) |
| color_o | output | 4 | Emitted colour, 0 when idle or transparent |
| valid_o | output | 1 | High for a non-transparent emitted pixel |

## Verification
The assertions assume that `xpos_i` changes only after an enabled edge, as it does when it comes from the display column shifted right by one, and that `pix_en_i` alternates as that column's lowest bit. The random lines drive exactly this pattern. They also keep the start column at 311 or below, so that all eight pixels land within the same logical line. The directed cases leave that pattern on purpose: a line with the enable held low, irregular enable gaps, a load that coincides with a match, and a reload in mid-row. These cases are checked against the bench's cycle model rather than against any timing assumption.

// File: rtl/sls_pkg.sv
package sls_pkg;
  localparam int unsigned PIX_W_D  = 4;
  localparam int unsigned NPIX_D   = 8;
  localparam int unsigned X_W_D    = 9;
endpackage

// File: rtl/sls_row_reg.sv
module sls_row_reg #(
  parameter int unsigned ROW_W = 32,
  parameter int unsigned X_W   = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [X_W-1:0]   start_i,
  input  logic             flip_i,
  output logic [ROW_W-1:0] row_q,
  output logic [X_W-1:0]   start_q,
  output logic             flip_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      row_q   <= '0;
      start_q <= '0;
      flip_q  <= 1'b0;
    end else if (load_i) begin
      row_q   <= row_i;
      start_q <= start_i;
      flip_q  <= flip_i;
    end
  end

  a_r2_capture: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (row_q == $past(row_i)) && (start_q == $past(start_i)));
endmodule

// File: rtl/sls_trigger.sv
module sls_trigger #(
  parameter int unsigned X_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load_i,
  input  logic           en_i,
  input  logic [X_W-1:0] xpos_i,
  input  logic [X_W-1:0] start_q,
  output logic           fire_o,
  output logic           armed_o
);
  logic armed_q;
  logic hit;

  assign hit     = (xpos_i == start_q);
  assign fire_o  = armed_q && en_i && !load_i && hit;
  assign armed_o = armed_q;

  always_ff @(posedge clk) begin
    if (!rst_n)      armed_q <= 1'b0;
    else if (load_i) armed_q <= 1'b1;
    else if (fire_o) armed_q <= 1'b0;
  end

  a_r7_one_shot: assert property (@(posedge clk) disable iff (!rst_n)
    fire_o |=> !armed_q);
  a_r2_arm: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> armed_q);
  a_r3_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_i && !load_i) |=> (armed_q == $past(armed_q)));
endmodule

// File: rtl/sls_seq.sv
module sls_seq #(
  parameter int unsigned NPIX = 8,
  localparam int unsigned IW  = $clog2(NPIX)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic          en_i,
  input  logic          fire_i,
  output logic          run_o,
  output logic [IW-1:0] idx_o,
  output logic          done_o
);
  localparam logic [IW-1:0] LAST = IW'(NPIX - 1);
  logic          run_q;
  logic [IW-1:0] idx_q;

  assign done_o = run_q && en_i && !load_i && (idx_q == LAST);
  assign run_o  = run_q;
  assign idx_o  = idx_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_q <= 1'b0;
      idx_q <= '0;
    end else if (load_i) begin
      run_q <= 1'b0;
      idx_q <= '0;
    end else if (fire_i) begin
      run_q <= 1'b1;
      idx_q <= '0;
    end else if (run_q && en_i) begin
      if (idx_q == LAST) begin
        run_q <= 1'b0;
        idx_q <= '0;
      end else begin
        idx_q <= idx_q + 1'b1;
      end
    end
  end

  a_r7_stop: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !run_q);
  a_r3_start: assert property (@(posedge clk) disable iff (!rst_n)
    fire_i |=> (run_q && idx_q == '0));
  a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
    (run_q && en_i && !load_i && !done_o) |=> (run_q && idx_q == $past(idx_q) + 1'b1));
endmodule

// File: rtl/sprite_line_shifter.sv
module sprite_line_shifter
  import sls_pkg::*;
#(
  parameter int unsigned PIX_W = PIX_W_D,
  parameter int unsigned NPIX  = NPIX_D,
  parameter int unsigned X_W   = X_W_D,
  localparam int unsigned ROW_W = PIX_W * NPIX,
  localparam int unsigned IW    = $clog2(NPIX)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [ROW_W-1:0] row_i,
  input  logic [X_W-1:0]   xstart_i,
  input  logic             hflip_i,
  input  logic             pix_en_i,
  input  logic [X_W-1:0]   xpos_i,
  output logic [PIX_W-1:0] color_o,
  output logic             valid_o
);
  function automatic logic [PIX_W-1:0] pick_pixel(
    input logic [ROW_W-1:0] row, input logic [IW-1:0] idx, input logic flip);
    int unsigned slot;
    slot = flip ? (NPIX - 1 - int'(idx)) : int'(idx);
    return row[slot*PIX_W +: PIX_W];
  endfunction

  logic [ROW_W-1:0] row_q;
  logic [X_W-1:0]   start_q;
  logic             flip_q;
  logic             fire;
  logic             armed;
  logic             run;
  logic             done;
  logic [IW-1:0]    idx;
  logic [PIX_W-1:0] pix;

  sls_row_reg #(.ROW_W(ROW_W), .X_W(X_W)) u_row (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .row_i(row_i),
    .start_i(xstart_i), .flip_i(hflip_i),
    .row_q(row_q), .start_q(start_q), .flip_q(flip_q));

  sls_trigger #(.X_W(X_W)) u_trig (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .en_i(pix_en_i),
    .xpos_i(xpos_i), .start_q(start_q), .fire_o(fire), .armed_o(armed));

  sls_seq #(.NPIX(NPIX)) u_seq (
    .clk(clk), .rst_n(rst_n), .load_i(load_i), .en_i(pix_en_i),
    .fire_i(fire), .run_o(run), .idx_o(idx), .done_o(done));

  assign pix     = pick_pixel(row_q, idx, flip_q);
  assign color_o = run ? pix : '0;
  assign valid_o = run && (pix != '0);

  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!pix_en_i && !load_i) |=> $stable(color_o) && $stable(valid_o));
  a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (color_o == '0) && !valid_o);
  a_r10_single_source: assert property (@(posedge clk) disable iff (!rst_n)
    !(run && armed));
  a_r8_transparent: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (color_o != '0));
endmodule

// File: tb/sim_sprite_line_shifter.sv
module sim_sprite_line_shifter;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        load_i = 0;
  logic [31:0] row_i = 0;
  logic [8:0]  xstart_i = 0;
  logic        hflip_i = 0;
  logic        pix_en_i = 0;
  logic [8:0]  xpos_i = 0;
  logic [3:0]  color_o;
  logic        valid_o;

  int checks = 0, fails = 0;
  // reference model state
  logic [31:0] m_row = 0; logic [8:0] m_start = 0; logic m_flip = 0;
  logic m_armed = 0, m_on = 0; int m_k = 0;

  always #5 clk = ~clk;

  sprite_line_shifter u0 (.clk(clk), .rst_n(rst_n), .load_i(load_i), .row_i(row_i),
    .xstart_i(xstart_i), .hflip_i(hflip_i), .pix_en_i(pix_en_i), .xpos_i(xpos_i),
    .color_o(color_o), .valid_o(valid_o));

  function automatic logic [3:0] nib(input logic [31:0] r, input int k, input logic f);
    int p;
    p = f ? 28 - 4*k : 4*k;   // R5 low nibble first, R6 high nibble first
    return (r >> p) & 32'hF;
  endfunction

  task automatic check(input string req);
    logic [3:0] ec; logic ev;
    ec = m_on ? nib(m_row, m_k, m_flip) : 4'h0;
    ev = ec != 0;
    checks++;
    if (color_o !== ec || valid_o !== ev) begin
      fails++;
      $display("FAIL %s color=%0h valid=%0b expected color=%0h valid=%0b", req, color_o, valid_o, ec, ev);
    end
  endtask

  task automatic step(input logic ld, input logic [31:0] r, input logic [8:0] s,
                      input logic f, input logic en, input logic [8:0] x);
    string req;
    load_i = ld; row_i = r; xstart_i = s; hflip_i = f; pix_en_i = en; xpos_i = x;
    @(posedge clk);
    if (ld) begin m_row = r; m_start = s; m_flip = f; m_armed = 1; m_on = 0; end
    else if (en) begin
      if (m_on) begin if (m_k == 7) m_on = 0; else m_k++; end
      else if (m_armed && x == m_start) begin m_on = 1; m_k = 0; m_armed = 0; end
    end
    #2;
    if (ld) req = "R9/R2";
    else if (!m_on) req = "R10/R7/R3";
    else if (nib(m_row, m_k, m_flip) == 0) req = "R8";
    else req = m_flip ? "R6/R4" : "R5/R4";
    check(req);
    load_i = 0;
  endtask

  task automatic line(input logic [31:0] r, input logic [8:0] s, input logic f,
                      input logic do_load);
    if (do_load) step(1, r, s, f, 0, 0);
    for (int h = 0; h < 640; h++) step(0, 0, 0, 0, h[0], 9'(h >> 1));
  endtask

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(posedge clk);
    #2; check("R1");
    rst_n = 1;
    line(0, 0, 0, 0);                       // R1: no load, nothing
    line(32'h87654321, 9'd0, 0, 1);         // R5 start column 0
    line(0, 0, 0, 0);                       // R7 one-shot: no re-fire
    line(32'h87654321, 9'd311, 1, 1);       // R6 last column in range
    line(32'h0F0F0F0F, 9'd100, 0, 1);       // R8 transparent pixels
    // R3: enable held low, matching column never fires
    step(1, 32'hFFFFFFFF, 9'd5, 0, 0, 0);
    for (int h = 0; h < 640; h++) step(0, 0, 0, 0, 0, 9'(h >> 1));
    line(0, 0, 0, 0);                       // still armed, fires now
    // R2: load coincides with a matching enabled cycle
    step(1, 32'h11111111, 9'd7, 0, 0, 0);
    step(1, 32'h22222222, 9'd7, 0, 1, 9'd7);
    for (int i = 0; i < 20; i++) step(0, 0, 0, 0, 1, 9'(7 + i));
    // R9: reload mid-row re-arms with new start
    step(1, 32'h76543210 | 32'h1, 9'd20, 0, 0, 0);
    for (int h = 40; h < 48; h++) step(0, 0, 0, 0, h[0], 9'(h >> 1));
    step(1, 32'hABCDEF12, 9'd30, 1, 0, 9'd24);
    for (int h = 48; h < 100; h++) step(0, 0, 0, 0, h[0], 9'(h >> 1));
    // R4: irregular enable gaps
    step(1, 32'h9ABCDEF1, 9'd3, 0, 0, 0);
    for (int x = 0; x < 16; x++) begin
      for (int g = 0; g < int'($urandom_range(4, 0)); g++) step(0, 0, 0, 0, 0, 9'(x));
      step(0, 0, 0, 0, 1, 9'(x));
    end
    // random lines
    for (int n = 0; n < 30; n++)
      line($urandom, 9'($urandom_range(311, 0)), 1'($urandom), 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #5_000_000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule